// File: doc/BRIEF.md
# CSR Command Register Handler

This block takes control and status register (CSR) commands from the head of a command inlet and completes them one at a time through a single-entry occupancy register. A command is accepted only while that register is empty. While it is full, the inlet head is held back.

A write command does not carry its data. When the write is accepted, the block issues a pull identifier and a sequence tag toward a pull arbiter. It also records the tag and the target address in a small pull-in-progress FIFO. When pull data comes back carrying the recorded tag, the data lands in the addressed CSR and the occupancy register empties.

A read command inserts the CSR value into a push-data FIFO that it shares with memory read data. The block writes on the first cycle in which memory data is not being written there. If memory traffic holds the FIFO input for too long, the block asks for a one-cycle bubble on the memory input and completes in that bubble.

Top module: `csr_cmd_handler`

## Requirements
- R1: `cmd_accept` equals `cmd_valid` while the occupancy register is empty, and is 0 while it holds a command. An accepted command occupies the register from the next cycle on.
- R2: In the cycle a write command is accepted, `pull_id_valid` is 1, `pull_id` equals `cmd_pull_id`, and `pull_tag` equals the number of writes accepted earlier since reset, modulo 8 (3-bit tag). `pull_id_valid` is 0 in every other cycle.
- R3: A cycle with `pull_dv` = 1 and `pull_dv_tag` equal to the outstanding write's tag writes `pull_data` into that write's CSR address. The register is free from the next cycle, so `cmd_accept` can be 1 one cycle later.
- R4: Pull data whose tag differs from the outstanding write's tag, or that arrives with no write outstanding, changes no CSR and does not free the register.
- R5: After a read is accepted, `push_csr_valid` is 1, with `push_csr_data` holding the addressed CSR value, in the first following cycle with `mem_wr` = 0. It is 0 in every cycle with `mem_wr` = 1 and whenever no read is pending.
- R6: `bubble_req` becomes 1 in the pending-read cycle that follows 8 consecutive pending cycles with `mem_wr` = 1. It stays 1 until the read's data is inserted. A read therefore waits at most 8 cycles when the memory side honours the bubble.
- R7: The CSR bank holds 8 registers of 32 bits at addresses 0 to 7 of a 4-bit address field. Addresses 8 to 15 read as zero, and writes to them are discarded, although they still complete and free the register.
- R8: After a read's data is inserted, the register is free, and a new command is accepted in the next cycle.
- R9: After reset the register is empty, `pull_id_valid`, `push_csr_valid` and `bubble_req` are 0, all CSRs read zero, and the tag count starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A CSR command sits at the inlet head |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | 4 | CSR address of the command |
| cmd_pull_id | input | 8 | Pull identifier supplied with a write |
| cmd_accept | output | 1 | Command taken from the inlet head this cycle |
| pull_id_valid | output | 1 | Pull request issued to the pull arbiter |
| pull_id | output | 8 | Pull identifier of the request |
| pull_tag | output | 3 | Tag that the returning pull data will carry |
| pull_dv | input | 1 | Pull data valid |
| pull_dv_tag | input | 3 | Tag carried by the pull data |
| pull_data | input | 32 | Pull data word |
| mem_wr | input | 1 | Memory read data is being written into the push-data FIFO |
| bubble_req | output | 1 | Request for one idle cycle on the memory input |
| push_csr_valid | output | 1 | CSR read data written into the push-data FIFO this cycle |
| push_csr_data | output | 32 | CSR read data |

## Verification
Every address, including the eight unmapped ones, is written and read back. Pull-data return delays of zero to three cycles show whether the register frees on the returning data rather than on a fixed delay. Reads run against memory-stall runs of 0 to 15 cycles. Runs shorter than eight separate plain opportunistic insertion from bubble-driven insertion, and longer runs show that the wait never exceeds the bubble limit. Wrong-tag and stray pull data, and commands held at the inlet while the register is busy, separate correct tag matching and back-pressure from a block that frees early or accepts while occupied.

// File: rtl/csrh_pkg.sv
package csrh_pkg;

  // An address selects a bank register only below the bank size.
  function automatic logic in_bank(input int addr, input int num_regs);
    return addr < num_regs;
  endfunction

  // Circular increment over 0 .. limit-1.
  function automatic int wrap_inc(input int value, input int limit);
    return (value + 1 >= limit) ? 0 : value + 1;
  endfunction

endpackage

// File: rtl/csrh_tag_fifo.sv
module csrh_tag_fifo #(
  parameter int WIDTH = 7,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][WIDTH-1:0] slots;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        slots[wr_ptr] <= push_data;
        wr_ptr <= PTR_W'(csrh_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      end
      if (do_pop)
        rd_ptr <= PTR_W'(csrh_pkg::wrap_inc(int'(rd_ptr), DEPTH));
      if (do_push && !do_pop)
        count <= count + 1'b1;
      else if (do_pop && !do_push)
        count <= count - 1'b1;
    end
  end

  // R2: a tag is never offered to a full FIFO
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R2: a recorded tag is visible at the head the next cycle
  assert_tag_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);

endmodule

// File: rtl/csrh_reg_bank.sv
module csrh_reg_bank #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic wr_mapped;

  assign wr_mapped = csrh_pkg::in_bank(int'(wr_addr), NUM_REGS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_en && wr_addr == ADDR_W'(i))
          regs[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (csrh_pkg::in_bank(int'(rd_addr), NUM_REGS))
      rd_data = regs[IDX_W'(rd_addr)];
  end

  // R7: a write to an unmapped address leaves the whole bank untouched
  assert_ignore_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mapped) |=> $stable(regs));

  // R3: a mapped write lands its data
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mapped && rd_addr == wr_addr) |=> (regs[IDX_W'($past(wr_addr))] == $past(wr_data)));

endmodule

// File: rtl/csrh_push_slot.sv
module csrh_push_slot #(
  parameter int BUBBLE_AFTER = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic mem_wr,
  output logic slot_take,
  output logic bubble_req
);
  localparam int CNT_W = $clog2(BUBBLE_AFTER + 1);

  logic [CNT_W-1:0] stall_cnt;
  logic stalled;

  assign stalled    = pending && mem_wr;
  assign slot_take  = pending && !mem_wr;
  assign bubble_req = pending && (stall_cnt >= CNT_W'(BUBBLE_AFTER));

  always_ff @(posedge clk) begin
    if (!rst_n)
      stall_cnt <= '0;
    else if (!pending)
      stall_cnt <= '0;
    else if (stalled && stall_cnt < CNT_W'(BUBBLE_AFTER))
      stall_cnt <= stall_cnt + 1'b1;
  end

  // R6: once raised, the bubble request holds while memory keeps the slot
  assert_bubble_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble_req && mem_wr) |=> bubble_req);

  // R6: the request rises only after a stalled cycle
  assert_bubble_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bubble_req) |-> $past(stalled));

  // R5: taking the slot ends the wait, so the request drops
  assert_take_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_take |=> !bubble_req);

endmodule

// File: rtl/csr_cmd_handler.sv
module csr_cmd_handler #(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 4,
  parameter int NUM_REGS     = 8,
  parameter int PID_W        = 8,
  parameter int TAG_W        = 3,
  parameter int PP_DEPTH     = 2,
  parameter int BUBBLE_AFTER = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PID_W-1:0]  cmd_pull_id,
  output logic              cmd_accept,
  output logic              pull_id_valid,
  output logic [PID_W-1:0]  pull_id,
  output logic [TAG_W-1:0]  pull_tag,
  input  logic              pull_dv,
  input  logic [TAG_W-1:0]  pull_dv_tag,
  input  logic [DATA_W-1:0] pull_data,
  input  logic              mem_wr,
  output logic              bubble_req,
  output logic              push_csr_valid,
  output logic [DATA_W-1:0] push_csr_data
);
  localparam int ENTRY_W = TAG_W + ADDR_W;

  // occupancy register
  logic              busy_q;
  logic              is_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_q;

  // named internal events
  logic wr_accept, rd_accept, rd_pending, pull_hit, slot_take;
  logic [ENTRY_W-1:0] pp_head;
  logic pp_empty, pp_full;
  logic [TAG_W-1:0]  head_tag;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] bank_rd;

  assign cmd_accept = cmd_valid && !busy_q;
  assign wr_accept  = cmd_accept && cmd_write;
  assign rd_accept  = cmd_accept && !cmd_write;
  assign rd_pending = busy_q && !is_wr_q;

  assign pull_id_valid = wr_accept;
  assign pull_id       = cmd_pull_id;
  assign pull_tag      = tag_q;

  assign head_tag  = pp_head[ENTRY_W-1 -: TAG_W];
  assign head_addr = pp_head[ADDR_W-1:0];
  assign pull_hit  = pull_dv && !pp_empty && (pull_dv_tag == head_tag);

  csrh_tag_fifo #(.WIDTH(ENTRY_W), .DEPTH(PP_DEPTH)) u_pp_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_accept),
    .push_data ({tag_q, cmd_addr}),
    .pop       (pull_hit),
    .head      (pp_head),
    .empty     (pp_empty),
    .full      (pp_full)
  );

  csrh_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pull_hit),
    .wr_addr (head_addr),
    .wr_data (pull_data),
    .rd_addr (addr_q),
    .rd_data (bank_rd)
  );

  csrh_push_slot #(.BUBBLE_AFTER(BUBBLE_AFTER)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .pending    (rd_pending),
    .mem_wr     (mem_wr),
    .slot_take  (slot_take),
    .bubble_req (bubble_req)
  );

  assign push_csr_valid = slot_take;
  assign push_csr_data  = bank_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      tag_q   <= '0;
    end else begin
      if (cmd_accept) begin
        busy_q  <= 1'b1;
        is_wr_q <= cmd_write;
        addr_q  <= cmd_addr;
      end else if (pull_hit || slot_take) begin
        busy_q  <= 1'b0;
      end
      if (wr_accept)
        tag_q <= TAG_W'(csrh_pkg::wrap_inc(int'(tag_q), 1 << TAG_W));
    end
  end

  // R1: an accepted command occupies the register next cycle
  assert_accept_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy_q);

  // R1: nothing is taken from the inlet while occupied
  assert_hold_inlet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !pull_hit && !slot_take) |=> !cmd_accept);

  // R3: matching pull data frees the register
  assert_pull_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pull_hit |=> !busy_q);

  // R2: a pull request always leaves an entry behind
  assert_pull_tracked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pull_id_valid |=> !pp_empty);

  // R8: inserting read data frees the register
  assert_push_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_csr_valid |=> !busy_q);

  // R5: read data never collides with memory data
  assert_no_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_csr_valid |-> (!mem_wr && busy_q));

endmodule

// File: tb/csr_cmd_handler_test.sv
module csr_cmd_handler_test;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [3:0]  cmd_addr = '0;
  logic [7:0]  cmd_pull_id = '0;
  logic        cmd_accept, pull_id_valid;
  logic [7:0]  pull_id;
  logic [2:0]  pull_tag;
  logic        pull_dv = 1'b0;
  logic [2:0]  pull_dv_tag = '0;
  logic [31:0] pull_data = '0;
  logic        mem_wr = 1'b0;
  logic        bubble_req, push_csr_valid;
  logic [31:0] push_csr_data;

  int compared = 0, mismatched = 0;
  int wr_count = 0;
  bit finished = 0;
  logic [31:0] model [16];

  always #4 clk = ~clk;

  csr_cmd_handler uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_pull_id(cmd_pull_id), .cmd_accept(cmd_accept),
    .pull_id_valid(pull_id_valid), .pull_id(pull_id), .pull_tag(pull_tag),
    .pull_dv(pull_dv), .pull_dv_tag(pull_dv_tag), .pull_data(pull_data),
    .mem_wr(mem_wr), .bubble_req(bubble_req), .push_csr_valid(push_csr_valid),
    .push_csr_data(push_csr_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pattern(input int a, input int round);
    return (32'h9E37_79B9 * (a + 1)) ^ (32'h0101_0101 * round);
  endfunction

  task automatic do_write(input int a, input logic [31:0] v, input int delay, input bit hold_other);
    logic [2:0] exp_tag;
    exp_tag = 3'(wr_count % 8);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = 4'(a); cmd_pull_id = 8'(a * 7 + 3);
    #1;
    check(cmd_accept == 1, "R1 write accept", 32'(cmd_accept), 1);
    check(pull_id_valid == 1, "R2 pull valid", 32'(pull_id_valid), 1);
    check(pull_id == 8'(a * 7 + 3), "R2 pull id", 32'(pull_id), 32'(a * 7 + 3));
    check(pull_tag == exp_tag, "R2 pull tag", 32'(pull_tag), 32'(exp_tag));
    @(posedge clk);
    for (int j = 0; j < delay; j++) begin
      @(negedge clk);
      cmd_valid = hold_other; cmd_write = 0;
      #1;
      if (hold_other) check(cmd_accept == 0, "R1 held while busy", 32'(cmd_accept), 0);
      check(pull_id_valid == 0, "R2 no extra pull", 32'(pull_id_valid), 0);
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 0; pull_dv = 1; pull_dv_tag = exp_tag; pull_data = v;
    @(posedge clk);
    @(negedge clk);
    pull_dv = 0;
    if (a < NREG) model[a] = v;
    wr_count++;
  endtask

  task automatic do_read(input int a, input int k);
    int exp_i;
    bit done;
    exp_i = (k < 8) ? k : 8;
    done = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_addr = 4'(a); mem_wr = 0;
    #1;
    check(cmd_accept == 1, "R1 read accept", 32'(cmd_accept), 1);
    check(push_csr_valid == 0, "R5 no early push", 32'(push_csr_valid), 0);
    @(posedge clk);
    for (int i = 0; i < 20 && !done; i++) begin
      bit exp_b;
      @(negedge clk);
      cmd_valid = 0;
      exp_b = (i >= 8);
      mem_wr = (i < k) && !exp_b;
      #1;
      check(bubble_req == exp_b, "R6 bubble", 32'(bubble_req), 32'(exp_b));
      if (!mem_wr) begin
        check(push_csr_valid == 1, "R5 push in free slot", 32'(push_csr_valid), 1);
        check(push_csr_data == model[a], "R7 read value", push_csr_data, model[a]);
        check(i == exp_i, "R6 wait bound", 32'(i), 32'(exp_i));
        done = 1;
      end else begin
        check(push_csr_valid == 0, "R5 no push under mem_wr", 32'(push_csr_valid), 0);
      end
      @(posedge clk);
    end
    @(negedge clk);
    mem_wr = 0;
    #1;
    check(push_csr_valid == 0 && bubble_req == 0, "R8 idle after read",
          {30'd0, push_csr_valid, bubble_req}, 0);
  endtask

  task automatic r8_back_to_back(input int a);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_addr = 4'(a); mem_wr = 0;
    #1;
    check(cmd_accept == 1, "R1 accept", 32'(cmd_accept), 1);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(push_csr_valid == 1 && push_csr_data == model[a], "R5 immediate push", push_csr_data, model[a]);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(cmd_accept == 1, "R8 accept right after push", 32'(cmd_accept), 1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    #1;
    check(push_csr_valid == 1 && push_csr_data == model[a], "R8 second read", push_csr_data, model[a]);
    @(posedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [2:0] t;
    for (int a = 0; a < 16; a++) model[a] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R9: reset state
    check(cmd_accept == 0, "R9 no accept idle", 32'(cmd_accept), 0);
    check(pull_id_valid == 0, "R9 no pull", 32'(pull_id_valid), 0);
    check(push_csr_valid == 0, "R9 no push", 32'(push_csr_valid), 0);
    check(bubble_req == 0, "R9 no bubble", 32'(bubble_req), 0);

    // R9: every address reads zero after reset
    for (int a = 0; a < 16; a++) do_read(a, 0);

    // R2, R3, R7: write every address with varied return delay
    for (int a = 0; a < 16; a++) do_write(a, pattern(a, 1), a % 4, (a % 2) == 1);

    // R5, R6, R7: read every address under stall runs 0..15
    for (int a = 0; a < 16; a++) do_read(a, a);

    // second round, reversed stall lengths
    for (int a = 0; a < 16; a++) do_write(a, pattern(a, 2), 3 - (a % 4), 1);
    for (int a = 0; a < 16; a++) do_read(a, 15 - a);

    // R8: back-to-back reads
    r8_back_to_back(5);

    // R4: wrong tag does not free or write; right tag does (R3)
    t = 3'(wr_count % 8);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = 4'd3; cmd_pull_id = 8'h55;
    #1;
    check(cmd_accept == 1 && pull_tag == t, "R2 tag before wrong-tag test", 32'(pull_tag), 32'(t));
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; pull_dv = 1; pull_dv_tag = t + 3'd1; pull_data = 32'hDEAD_BEEF;
    @(posedge clk);
    @(negedge clk);
    pull_dv = 0; cmd_valid = 1; cmd_write = 0; cmd_addr = 4'd3;
    #1;
    check(cmd_accept == 0, "R4 wrong tag keeps busy", 32'(cmd_accept), 0);
    @(posedge clk);
    @(negedge clk);
    pull_dv = 1; pull_dv_tag = t; pull_data = 32'hC0DE_0003;
    #1;
    check(cmd_accept == 0, "R3 still busy in data cycle", 32'(cmd_accept), 0);
    @(posedge clk);
    @(negedge clk);
    pull_dv = 0;
    #1;
    check(cmd_accept == 1, "R3 free after matching data", 32'(cmd_accept), 1);
    model[3] = 32'hC0DE_0003;
    wr_count++;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; mem_wr = 0;
    #1;
    check(push_csr_valid == 1 && push_csr_data == 32'hC0DE_0003, "R4 wrong data not stored",
          push_csr_data, 32'hC0DE_0003);
    @(posedge clk);

    // R4: stray pull data with nothing outstanding
    @(negedge clk);
    pull_dv = 1; pull_dv_tag = 3'(wr_count % 8); pull_data = 32'h1234_5678; cmd_addr = 4'd3;
    @(posedge clk);
    @(negedge clk);
    pull_dv = 0;
    do_read(3, 2);
    check(model[3] == 32'hC0DE_0003, "R4 stray data model", model[3], 32'hC0DE_0003);

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule